// File: doc/BRIEF.md
# Logical and Unit Condition Evaluator

This block decides whether the condition attached to a 32-bit integer logical, unit or shift/extract/deposit operation holds. The execute stage feeds it the finished result word, the per-bit carry-out vector of the adder, a class select, the 3-bit condition code (instruction bits 15..13) and the negate flag (instruction bit 12). It returns one bit, `cond_true`, which the pipeline uses to nullify the next instruction. The block does not produce the result itself, and it does not raise traps.

Each class has its own eight-entry table. The logical class tests the result for zero, negative, non-positive or odd. The unit class treats the word as lanes. It looks for a zero byte or a zero halfword in the result. It also looks for a carry out of the top bit of any 4-bit digit, byte or halfword, using the carry vector. The shift/extract/deposit class has a full set of eight tests, including always, non-zero and even.

The negate flag complements whatever the table yields. When the `PIPE` parameter is 1 (the default), an output register captures the verdict on each cycle with `in_valid` high. When `PIPE` is 0, the verdict passes straight through.

Top module: `cond_eval`

## Requirements
- R1: With `op_class`=0 (logical) and `negate`=0, codes give: 0 false, 1 result==0, 2 result[31]==1, 3 result[31]==1 or result==0, 7 result[0]==1.
- R2: With `op_class`=1 (unit) and `negate`=0, code 2 is true when any byte lane of the result (bits 8k+7..8k) is zero, and code 3 is true when either halfword lane (bits 15..0 or 31..16) is zero. Code 0 is false.
- R3: With `op_class`=1 and `negate`=0, code 4 is true when any of carry bits 3,7,...,31 (mask 0x88888888) is set. Code 6 tests carry bits 7,15,23,31 (mask 0x80808080). Code 7 tests carry bits 15 and 31 (mask 0x80008000). Carry bit i is the carry out of result bit i.
- R4: With `op_class`=2 (shift/extract/deposit) and `negate`=0, codes 0..7 give in turn: false, result==0, result[31]==1, result[0]==1, true, result!=0, result[31]==0, result[0]==0.
- R5: Undefined entries evaluate false before negation. These are logical codes 4, 5 and 6, unit codes 1 and 5, and every code with `op_class`=3.
- R6: With `negate`=1 the output is the complement of the table value, including undefined entries.
- R7: With PIPE=1, `cond_true` shows the verdict for the inputs sampled at the previous rising edge with `in_valid`=1. It holds its value after an edge with `in_valid`=0. A synchronous active-high `rst` clears it to 0.
- R8: With PIPE=1, `out_valid` equals `in_valid` from the previous edge, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry an operation to evaluate |
| op_class | input | 2 | 0 logical, 1 unit, 2 shift/extract/deposit, 3 reserved |
| cond_code | input | 3 | Condition code field |
| negate | input | 1 | Complement the table result |
| result | input | 32 | Operation result word |
| carry | input | 32 | Carry out of each adder bit |
| cond_true | output | 1 | Condition holds |
| out_valid | output | 1 | cond_true carries a fresh verdict |

## Verification
Several properties are checked on every cycle. One is the valid pipeline and the holding of the verdict on idle edges. Another is that the always and never entries follow the negate flag. Undefined codes are checked to stay false, and the zero-byte verdict is compared against the subtract-and-mask formula. The bench's scenarios cover what only chosen data can show. This includes lane boundaries such as a single zero byte at each position, a carry set only in a bit outside the mask, and sign and parity edges. Every class and code is also run under both polarities of the negate flag against the bench's own model.

// File: rtl/cond_pkg.sv
package cond_pkg;

    typedef enum logic [1:0] {
        CLS_LOGIC = 2'd0,
        CLS_UNIT  = 2'd1,
        CLS_SHIFT = 2'd2,
        CLS_RSVD  = 2'd3
    } cond_class_e;

    // Mask with the top bit of every LANE-bit lane set.
    function automatic logic [31:0] lane_top_mask(input int lane);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if ((i % lane) == lane - 1) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cond_logic_tbl.sv
module cond_logic_tbl #(
    parameter int W = 32
) (
    input  logic [W-1:0] result,
    input  logic [2:0]   code,
    output logic         hit
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (result == '0);
    assign is_neg  = result[W-1];

    always_comb begin
        unique case (code)
            3'd1:    hit = is_zero;
            3'd2:    hit = is_neg;
            3'd3:    hit = is_neg | is_zero;
            3'd7:    hit = result[0];
            default: hit = 1'b0;   // never, and the undefined entries 4..6
        endcase
    end
endmodule

// File: rtl/cond_unit_tbl.sv
module cond_unit_tbl #(
    parameter int W = 32
) (
    input  logic [W-1:0] result,
    input  logic [W-1:0] carry,
    input  logic [2:0]   code,
    output logic         hit
);
    localparam int NBYTE = W / 8;
    localparam int NHALF = W / 16;
    localparam int NDIG  = W / 4;

    logic [NBYTE-1:0] byte_zero;
    logic [NHALF-1:0] half_zero;
    logic [NDIG-1:0]  dig_cy;
    logic [NBYTE-1:0] byte_cy;
    logic [NHALF-1:0] half_cy;

    genvar g;
    generate
        for (g = 0; g < NBYTE; g++) begin : g_byte
            assign byte_zero[g] = (result[8*g +: 8] == 8'd0);
            assign byte_cy[g]   = carry[8*g + 7];
        end
        for (g = 0; g < NHALF; g++) begin : g_half
            assign half_zero[g] = (result[16*g +: 16] == 16'd0);
            assign half_cy[g]   = carry[16*g + 15];
        end
        for (g = 0; g < NDIG; g++) begin : g_dig
            assign dig_cy[g] = carry[4*g + 3];
        end
    endgenerate

    always_comb begin
        unique case (code)
            3'd2:    hit = |byte_zero;
            3'd3:    hit = |half_zero;
            3'd4:    hit = |dig_cy;
            3'd6:    hit = |byte_cy;
            3'd7:    hit = |half_cy;
            default: hit = 1'b0;   // never, and the undefined entries 1 and 5
        endcase
    end
endmodule

// File: rtl/cond_shift_tbl.sv
module cond_shift_tbl #(
    parameter int W = 32
) (
    input  logic [W-1:0] result,
    input  logic [2:0]   code,
    output logic         hit
);
    logic nz;

    assign nz = |result;

    always_comb begin
        unique case (code)
            3'd0: hit = 1'b0;
            3'd1: hit = ~nz;
            3'd2: hit = result[W-1];
            3'd3: hit = result[0];
            3'd4: hit = 1'b1;
            3'd5: hit = nz;
            3'd6: hit = ~result[W-1];
            3'd7: hit = ~result[0];
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cond_eval.sv
module cond_eval #(
    parameter int W    = 32,
    parameter bit PIPE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   op_class,
    input  logic [2:0]   cond_code,
    input  logic         negate,
    input  logic [W-1:0] result,
    input  logic [W-1:0] carry,
    output logic         cond_true,
    output logic         out_valid
);
    import cond_pkg::*;

    cond_class_e cls;
    logic        hit_log;
    logic        hit_unit;
    logic        hit_shift;
    logic        table_hit;
    logic        verdict;

    assign cls = cond_class_e'(op_class);

    cond_logic_tbl #(.W(W)) u_log (
        .result (result),
        .code   (cond_code),
        .hit    (hit_log)
    );

    cond_unit_tbl #(.W(W)) u_unit (
        .result (result),
        .carry  (carry),
        .code   (cond_code),
        .hit    (hit_unit)
    );

    cond_shift_tbl #(.W(W)) u_shift (
        .result (result),
        .code   (cond_code),
        .hit    (hit_shift)
    );

    always_comb begin
        unique case (cls)
            CLS_LOGIC: table_hit = hit_log;
            CLS_UNIT:  table_hit = hit_unit;
            CLS_SHIFT: table_hit = hit_shift;
            default:   table_hit = 1'b0;
        endcase
    end

    assign verdict = table_hit ^ negate;

    generate
        if (PIPE) begin : g_reg
            logic q_true;
            logic q_valid;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q_true  <= 1'b0;
                    q_valid <= 1'b0;
                end else begin
                    q_valid <= in_valid;
                    if (in_valid) q_true <= verdict;
                end
            end
            assign cond_true = q_true;
            assign out_valid = q_valid;
        end else begin : g_comb
            assign cond_true = verdict;
            assign out_valid = in_valid;
        end
    endgenerate
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
    parameter int W    = 32,
    parameter bit PIPE = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   op_class,
    input logic [2:0]   cond_code,
    input logic         negate,
    input logic [W-1:0] result,
    input logic [W-1:0] carry,
    input logic         cond_true,
    input logic         out_valid
);
    logic undef_entry;
    logic [W-1:0] bz_probe;

    assign undef_entry = (op_class == 2'd3) ||
                         (op_class == 2'd0 && (cond_code == 3'd4 || cond_code == 3'd5 || cond_code == 3'd6)) ||
                         (op_class == 2'd1 && (cond_code == 3'd1 || cond_code == 3'd5));
    assign bz_probe = (result - {(W/8){8'h01}}) & ~result & {(W/8){8'h80}};

    generate
        if (PIPE) begin : g_chk
            // R8
            valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            // R8
            valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            // R7
            idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(cond_true));
            // R4
            always_entry_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_class == 2'd2 && cond_code == 3'd4 && !negate) |=> cond_true);
            // R6
            never_negated_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_class == 2'd2 && cond_code == 3'd0 && negate) |=> cond_true);
            // R5
            undef_false_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && undef_entry && !negate) |=> !cond_true);
            // R2
            byte_zero_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_class == 2'd1 && cond_code == 3'd2 && !negate)
                |=> (cond_true == ($past(bz_probe) != '0)));
            // R1
            log_eq_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && op_class == 2'd0 && cond_code == 3'd1 && !negate)
                |=> (cond_true == ($past(result) == '0)));
        end
    endgenerate
endmodule

bind cond_eval cond_eval_chk #(.W(W), .PIPE(PIPE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_class  (op_class),
    .cond_code (cond_code),
    .negate    (negate),
    .result    (result),
    .carry     (carry),
    .cond_true (cond_true),
    .out_valid (out_valid)
);

// File: tb/cond_eval_test.sv
module cond_eval_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op_class = '0;
    logic [2:0]  cond_code = '0;
    logic        negate = 1'b0;
    logic [31:0] result = '0;
    logic [31:0] carry = '0;
    logic        cond_true;
    logic        out_valid;

    int    n_checks = 0;
    int    n_errors = 0;
    logic  exp_true = 1'b0;
    logic  exp_valid = 1'b0;
    string exp_tag = "R7";
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_eval uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
        .cond_code(cond_code), .negate(negate), .result(result), .carry(carry),
        .cond_true(cond_true), .out_valid(out_valid)
    );

    function automatic logic model(logic [1:0] c, logic [2:0] k, logic n,
                                   logic [31:0] r, logic [31:0] cy);
        logic h;
        h = 1'b0;
        if (c == 2'd0) begin
            if (k == 1) h = (r == 0);
            else if (k == 2) h = ($signed(r) < 0);
            else if (k == 3) h = ($signed(r) <= 0);
            else if (k == 7) h = r[0];
        end else if (c == 2'd1) begin
            if (k == 2) h = (((r - 32'h01010101) & ~r & 32'h80808080) != 0);
            else if (k == 3) h = (((r - 32'h00010001) & ~r & 32'h80008000) != 0);
            else if (k == 4) h = ((cy & 32'h88888888) != 0);
            else if (k == 6) h = ((cy & 32'h80808080) != 0);
            else if (k == 7) h = ((cy & 32'h80008000) != 0);
        end else if (c == 2'd2) begin
            case (k)
                3'd1: h = (r == 0);
                3'd2: h = ($signed(r) < 0);
                3'd3: h = r[0];
                3'd4: h = 1'b1;
                3'd5: h = (r != 0);
                3'd6: h = ($signed(r) >= 0);
                3'd7: h = ~r[0];
                default: h = 1'b0;
            endcase
        end
        return h ^ n;
    endfunction

    function automatic string tag_of(logic [1:0] c, logic [2:0] k, logic n);
        if (n) return "R6";
        if (c == 2'd3 || (c == 2'd0 && k >= 4 && k <= 6) || (c == 2'd1 && (k == 1 || k == 5)))
            return "R5";
        if (c == 2'd0) return "R1";
        if (c == 2'd1) return (k == 4 || k == 6 || k == 7) ? "R3" : "R2";
        return "R4";
    endfunction

    task automatic step(logic rs, logic v, logic [1:0] c, logic [2:0] k, logic n,
                        logic [31:0] r, logic [31:0] cy);
        @(negedge clk);
        n_checks++;
        if (cond_true !== exp_true) begin
            n_errors++;
            $display("FAIL %s cond_true actual=%b expected=%b", exp_tag, cond_true, exp_true);
        end
        n_checks++;
        if (out_valid !== exp_valid) begin
            n_errors++;
            $display("FAIL R8 out_valid actual=%b expected=%b", out_valid, exp_valid);
        end
        rst = rs; in_valid = v; op_class = c; cond_code = k; negate = n;
        result = r; carry = cy;
        if (rs) begin
            exp_true = 1'b0; exp_valid = 1'b0; exp_tag = "R7";
        end else begin
            exp_valid = v;
            if (v) begin
                exp_true = model(c, k, n, r, cy);
                exp_tag  = tag_of(c, k, n);
            end else begin
                exp_tag = "R7";
            end
        end
    endtask

    task automatic go(logic [1:0] c, logic [2:0] k, logic n, logic [31:0] r, logic [31:0] cy);
        step(1'b0, 1'b1, c, k, n, r, cy);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_errors++;
                n_checks++;
                $display("FAIL watchdog expired");
                $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin
        // reset state (R7, R8), inputs active during reset are ignored
        step(1'b1, 1'b1, 2'd2, 3'd4, 1'b0, 32'h0, 32'h0);
        step(1'b1, 1'b1, 2'd2, 3'd4, 1'b0, 32'h0, 32'h0);
        step(1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 32'h0, 32'h0);

        // R1 logical table, sign and zero edges
        go(2'd0, 3'd1, 1'b0, 32'h0, 32'h0);
        go(2'd0, 3'd1, 1'b0, 32'h1, 32'h0);
        go(2'd0, 3'd2, 1'b0, 32'h80000000, 32'h0);
        go(2'd0, 3'd2, 1'b0, 32'h7fffffff, 32'h0);
        go(2'd0, 3'd3, 1'b0, 32'h0, 32'h0);
        go(2'd0, 3'd3, 1'b0, 32'h00000001, 32'h0);
        go(2'd0, 3'd7, 1'b0, 32'h00000003, 32'h0);
        go(2'd0, 3'd7, 1'b0, 32'h00000002, 32'h0);
        go(2'd0, 3'd0, 1'b0, 32'h0, 32'hffffffff);

        // R2 zero byte at each lane, and none
        for (int b = 0; b < 4; b++)
            go(2'd1, 3'd2, 1'b0, ~(32'hff << (8*b)), 32'h0);
        go(2'd1, 3'd2, 1'b0, 32'h01010101, 32'h0);
        go(2'd1, 3'd2, 1'b0, 32'h80808080, 32'h0);
        go(2'd1, 3'd3, 1'b0, 32'hffff0000, 32'h0);
        go(2'd1, 3'd3, 1'b0, 32'h0000ffff, 32'h0);
        go(2'd1, 3'd3, 1'b0, 32'h00ffff00, 32'h0);

        // R3 carries: in-mask single bits and out-of-mask neighbours
        go(2'd1, 3'd4, 1'b0, 32'h0, 32'h00000008);
        go(2'd1, 3'd4, 1'b0, 32'h0, 32'h77777777);
        go(2'd1, 3'd6, 1'b0, 32'h0, 32'h00008000);
        go(2'd1, 3'd6, 1'b0, 32'h0, 32'h08080808);
        go(2'd1, 3'd6, 1'b0, 32'h0, 32'h7f7f7f7f);
        go(2'd1, 3'd7, 1'b0, 32'h0, 32'h80000000);
        go(2'd1, 3'd7, 1'b0, 32'h0, 32'h00800080);

        // R4 full shift class table on two data words
        for (int k = 0; k < 8; k++) begin
            go(2'd2, 3'(k), 1'b0, 32'h0, 32'h0);
            go(2'd2, 3'(k), 1'b0, 32'h80000001, 32'h0);
        end

        // R5 undefined entries with data that would make other entries true
        go(2'd0, 3'd4, 1'b0, 32'h0, 32'hffffffff);
        go(2'd0, 3'd5, 1'b0, 32'h80000001, 32'hffffffff);
        go(2'd0, 3'd6, 1'b0, 32'h0, 32'hffffffff);
        go(2'd1, 3'd1, 1'b0, 32'h0, 32'hffffffff);
        go(2'd1, 3'd5, 1'b0, 32'h0, 32'hffffffff);
        for (int k = 0; k < 8; k++) go(2'd3, 3'(k), 1'b0, 32'h0, 32'hffffffff);

        // R6 negation, including an undefined entry
        go(2'd0, 3'd4, 1'b1, 32'h0, 32'h0);
        go(2'd0, 3'd1, 1'b1, 32'h0, 32'h0);
        go(2'd2, 3'd4, 1'b1, 32'h0, 32'h0);
        go(2'd1, 3'd2, 1'b1, 32'h12003456, 32'h0);

        // R7 hold while idle after a true verdict, then after a false one
        go(2'd2, 3'd4, 1'b0, 32'h0, 32'h0);
        step(1'b0, 1'b0, 2'd2, 3'd0, 1'b0, 32'h0, 32'h0);
        step(1'b0, 1'b0, 2'd2, 3'd0, 1'b0, 32'h0, 32'h0);
        go(2'd2, 3'd0, 1'b0, 32'h0, 32'h0);
        step(1'b0, 1'b0, 2'd2, 3'd4, 1'b0, 32'h0, 32'h0);

        // mixed random traffic across all classes and both polarities
        for (int i = 0; i < 600; i++)
            step(1'b0, 1'($urandom % 4 != 0), 2'($urandom), 3'($urandom), 1'($urandom),
                 ($urandom % 3 == 0) ? ($urandom & 32'h00ff00ff) : $urandom, $urandom);

        // reset mid-stream clears the verdict (R7)
        go(2'd2, 3'd4, 1'b0, 32'h0, 32'h0);
        step(1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 32'h0, 32'h0);
        step(1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 32'h0, 32'h0);
        step(1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 32'h0, 32'h0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule